// File: doc/BRIEF.md
# OSD character raster address generator

This block follows the video raster of an on-screen text overlay and, for every dot-clock cycle, reports which character cell of the text page is under the beam. It returns the text-memory row and column of that cell, the glyph line and the dot within the cell, and two flags. One flag says that a character dot is being drawn. The other says that the beam is inside the vertical band that holds the text page. A font lookup and a video mixer downstream consume these outputs.

The page is 12 rows of 24 cells, and each cell is 12 dots wide and 18 lines tall. Two 6-bit registers set where the page starts. The vertical offset counts whole lines from the frame strobe, and the horizontal offset counts dot-clock periods from the line strobe. A 2-bit size code for each row enlarges that row to twice or three times normal size. An enlarged row repeats every glyph line and stretches every dot by the same factor.

Top module: `osd_raster_addr`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: The first line strobe after a frame strobe starts line 0. Text row 0, glyph line 0 starts on the line whose index equals `vstart`, and `frame_win` is high from the first output update of that line.
- R3: If `hsync_stb` is sampled at edge 0, the first dot of column 0 (`pix_valid`=1, column 0, dot 0) appears on the outputs after edge `hstart`+1.
- R4: At normal size, the dot index runs 0 to 11 once per clock and the column runs 0 to 23, for 288 consecutive valid cycles. `pix_valid` then stays low until the next line strobe.
- R5: The size code of row r is `row_size[2r+1:2r]`: 00 and 11 select 1x, 01 selects 2x and 10 selects 3x. At factor N, each dot index is held for N clocks and the line carries 288×N valid cycles.
- R6: In a row of factor N, each glyph line 0 to 17 is shown on N consecutive lines, and the next row starts after 18×N lines.
- R7: After the last line of row 11, `frame_win` and `pix_valid` stay low until the next frame strobe.
- R8: A frame strobe clears the vertical position and drops `frame_win`. A line strobe in the same cycle as a frame strobe is not counted as a line.
- R9: Whenever `pix_valid` is low, row, column, glyph line and dot outputs are zero, and `pix_valid` is never high while `frame_win` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_stb | input | 1 | One-cycle strobe at the start of each line |
| vsync_stb | input | 1 | One-cycle strobe at the start of each frame |
| vstart | input | 6 | Vertical page offset in lines |
| hstart | input | 6 | Horizontal page offset in dot clocks |
| row_size | input | 24 | Two-bit size code per text row, row r at bits 2r+1:2r |
| mem_row | output | 4 | Text-memory row, 0 to 11 |
| mem_col | output | 5 | Text-memory column, 0 to 23 |
| glyph_line | output | 5 | Line within the glyph, 0 to 17 |
| glyph_dot | output | 4 | Dot within the glyph line, 0 to 11 |
| pix_valid | output | 1 | A character dot is being drawn |
| frame_win | output | 1 | Beam is inside the vertical text band |

## Verification
Every cycle of each driven line is compared against a model built from the requirements. This covers the offset boundaries of 0 and 63. A design off by one in the horizontal lead would shift every column by a dot, and one that counted the wrong line would start the page a line early or late. Frames mixing 3x, 2x, code 11 and 1x rows catch a size decoder that treats code 11 as a real factor. They also catch dot stretching that forgets the repeat count, and a row height that ignores the factor. The bench checks that the band stays closed after row 11 and does not wrap back to row 0. It also checks that a line strobe arriving together with a frame strobe is not counted, because counting it would open the page one line too soon.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'b00,
    SZ_TWO  = 2'b01,
    SZ_TRI  = 2'b10,
    SZ_ONEB = 2'b11
  } size_code_e;

  // Repeat count minus one for a size code.
  function automatic logic [1:0] rep_last(input logic [1:0] code);
    case (size_code_e'(code))
      SZ_TWO:  rep_last = 2'd1;
      SZ_TRI:  rep_last = 2'd2;
      default: rep_last = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/osd_vscan.sv
module osd_vscan
  import osd_raster_pkg::*;
#(
  parameter int ROWS   = 12,
  parameter int CELL_H = 18,
  parameter int POS_W  = 6,
  parameter int ROW_W  = 4,
  parameter int LINE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hs,
  input  logic               vs,
  input  logic [POS_W-1:0]   vstart,
  input  logic [2*ROWS-1:0]  row_size,
  output logic               vact,
  output logic [ROW_W-1:0]   row,
  output logic [LINE_W-1:0]  gl,
  output logic [1:0]         cur_last
);

  logic [POS_W-1:0] lcnt;
  logic             vdone;
  logic [1:0]       lrep;
  logic [1:0]       size_arr [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_size
    assign size_arr[r] = row_size[2*r +: 2];
  end

  assign cur_last = rep_last(size_arr[row]);

  always_ff @(posedge clk) begin
    if (rst || vs) begin
      lcnt  <= '0;
      vact  <= 1'b0;
      vdone <= 1'b0;
      row   <= '0;
      gl    <= '0;
      lrep  <= '0;
    end else if (hs) begin
      if (!vact && !vdone) begin
        if (lcnt == vstart) vact <= 1'b1;
        else                lcnt <= lcnt + 1'b1;
      end else if (vact) begin
        if (lrep == cur_last) begin
          lrep <= '0;
          if (gl == LINE_W'(CELL_H - 1)) begin
            gl <= '0;
            if (row == ROW_W'(ROWS - 1)) begin
              vact  <= 1'b0;
              vdone <= 1'b1;
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            gl <= gl + 1'b1;
          end
        end else begin
          lrep <= lrep + 1'b1;
        end
      end
    end
  end

  // R8
  vsync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    vs |=> (!vact && row == '0 && gl == '0));

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hs && !vs) |=> ($stable(row) && $stable(gl)));

  // R7
  done_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (vdone && !vs) |=> !vact);

endmodule

// File: rtl/osd_hscan.sv
module osd_hscan #(
  parameter int COLS   = 24,
  parameter int CELL_W = 12,
  parameter int POS_W  = 6,
  parameter int COL_W  = 5,
  parameter int DOT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs,
  input  logic [POS_W-1:0]  hstart,
  input  logic [1:0]        cur_last,
  output logic              run,
  output logic [COL_W-1:0]  col,
  output logic [DOT_W-1:0]  dot
);

  logic [POS_W-1:0] lead_cnt;
  logic             hdone;
  logic [1:0]       drep;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_cnt <= '0;
      run      <= 1'b0;
      hdone    <= 1'b1;
      col      <= '0;
      dot      <= '0;
      drep     <= '0;
    end else if (hs) begin
      lead_cnt <= '0;
      run      <= (hstart == '0);
      hdone    <= 1'b0;
      col      <= '0;
      dot      <= '0;
      drep     <= '0;
    end else if (run) begin
      if (drep == cur_last) begin
        drep <= '0;
        if (dot == DOT_W'(CELL_W - 1)) begin
          dot <= '0;
          if (col == COL_W'(COLS - 1)) begin
            run   <= 1'b0;
            hdone <= 1'b1;
          end else begin
            col <= col + 1'b1;
          end
        end else begin
          dot <= dot + 1'b1;
        end
      end else begin
        drep <= drep + 1'b1;
      end
    end else if (!hdone) begin
      lead_cnt <= lead_cnt + 1'b1;
      if (lead_cnt + 1'b1 == hstart) run <= 1'b1;
    end
  end

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !hs) |=> (!run || col == $past(col) ||
                      (col == $past(col) + COL_W'(1) && dot == '0)));

  // R5
  dot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !hs && drep != cur_last) |=> (dot == $past(dot) && col == $past(col)));

endmodule

// File: rtl/osd_raster_addr.sv
module osd_raster_addr #(
  parameter int ROWS   = 12,
  parameter int COLS   = 24,
  parameter int CELL_W = 12,
  parameter int CELL_H = 18,
  parameter int POS_W  = 6,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int LINE_W = $clog2(CELL_H),
  localparam int DOT_W  = $clog2(CELL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_stb,
  input  logic              vsync_stb,
  input  logic [POS_W-1:0]  vstart,
  input  logic [POS_W-1:0]  hstart,
  input  logic [2*ROWS-1:0] row_size,
  output logic [ROW_W-1:0]  mem_row,
  output logic [COL_W-1:0]  mem_col,
  output logic [LINE_W-1:0] glyph_line,
  output logic [DOT_W-1:0]  glyph_dot,
  output logic              pix_valid,
  output logic              frame_win
);

  logic              vact, run;
  logic [ROW_W-1:0]  row;
  logic [LINE_W-1:0] gl;
  logic [COL_W-1:0]  col;
  logic [DOT_W-1:0]  dot;
  logic [1:0]        cur_last;
  logic              vis;

  osd_vscan #(
    .ROWS(ROWS), .CELL_H(CELL_H), .POS_W(POS_W), .ROW_W(ROW_W), .LINE_W(LINE_W)
  ) u_vscan (
    .clk(clk), .rst(rst), .hs(hsync_stb), .vs(vsync_stb), .vstart(vstart),
    .row_size(row_size), .vact(vact), .row(row), .gl(gl), .cur_last(cur_last)
  );

  osd_hscan #(
    .COLS(COLS), .CELL_W(CELL_W), .POS_W(POS_W), .COL_W(COL_W), .DOT_W(DOT_W)
  ) u_hscan (
    .clk(clk), .rst(rst), .hs(hsync_stb), .hstart(hstart), .cur_last(cur_last),
    .run(run), .col(col), .dot(dot)
  );

  assign vis = vact && run;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_row    <= '0;
      mem_col    <= '0;
      glyph_line <= '0;
      glyph_dot  <= '0;
      pix_valid  <= 1'b0;
      frame_win  <= 1'b0;
    end else begin
      pix_valid  <= vis;
      frame_win  <= vact;
      mem_row    <= vis ? row : '0;
      mem_col    <= vis ? col : '0;
      glyph_line <= vis ? gl  : '0;
      glyph_dot  <= vis ? dot : '0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!pix_valid && !frame_win && mem_col == '0 && mem_row == '0));

  // R9
  valid_window_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> frame_win);

endmodule

// File: tb/test_osd_raster_addr.sv
module test_osd_raster_addr;

  localparam int ROWS = 12, COLS = 24, CW = 12, CH = 18;

  typedef struct {
    int v; int w; int r; int c; int l; int d;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync_stb = 1'b0;
  logic        vsync_stb = 1'b0;
  logic [5:0]  vstart = '0;
  logic [5:0]  hstart = '0;
  logic [23:0] row_size = '0;
  logic [3:0]  mem_row;
  logic [4:0]  mem_col;
  logic [4:0]  glyph_line;
  logic [3:0]  glyph_dot;
  logic        pix_valid, frame_win;

  int checks = 0, errors = 0;
  bit mon_on = 1'b0;
  exp_t q[$];

  int m_lcnt, m_vact, m_vdone, m_row, m_gl, m_rep;

  always #4 clk = ~clk;

  osd_raster_addr i_osd_raster_addr (
    .clk(clk), .rst(rst), .hsync_stb(hsync_stb), .vsync_stb(vsync_stb),
    .vstart(vstart), .hstart(hstart), .row_size(row_size),
    .mem_row(mem_row), .mem_col(mem_col), .glyph_line(glyph_line),
    .glyph_dot(glyph_dot), .pix_valid(pix_valid), .frame_win(frame_win)
  );

  function automatic int scale(int r);
    case (row_size[2*r +: 2])
      2'b01:   return 2;
      2'b10:   return 3;
      default: return 1;
    endcase
  endfunction

  task automatic check(bit ok, string req, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per output update.
  always @(posedge clk) begin
    #2;
    if (mon_on && q.size() > 0) begin
      exp_t e;
      string a, x;
      e = q.pop_front();
      a = $sformatf("v%0d w%0d r%0d c%0d l%0d d%0d", pix_valid, frame_win,
                    mem_row, mem_col, glyph_line, glyph_dot);
      x = $sformatf("v%0d w%0d r%0d c%0d l%0d d%0d", e.v, e.w, e.r, e.c, e.l, e.d);
      check(a == x, e.tag, a, x);
    end
  end

  task automatic model_clear();
    m_lcnt = 0; m_vact = 0; m_vdone = 0; m_row = 0; m_gl = 0; m_rep = 0;
  endtask

  // Driver: predicts one line, then issues its line strobe. Called at a negedge.
  task automatic run_line(int len, string tag);
    string t = tag;
    int n;
    if (!m_vact && !m_vdone) begin
      if (m_lcnt == int'(vstart)) begin
        m_vact = 1; m_row = 0; m_gl = 0; m_rep = 0;
      end else m_lcnt++;
    end else if (m_vact) begin
      if (m_rep == scale(m_row) - 1) begin
        m_rep = 0;
        if (m_gl == CH - 1) begin
          m_gl = 0;
          if (m_row == ROWS - 1) begin m_vact = 0; m_vdone = 1; end
          else m_row++;
        end else m_gl++;
      end else m_rep++;
    end
    if (m_vdone) t = "R7";
    n = scale(m_row);
    for (int j = 0; j < len; j++) begin
      exp_t e;
      e.v = 0; e.w = m_vact; e.r = 0; e.c = 0; e.l = 0; e.d = 0;
      if (m_vact != 0 && j >= int'(hstart)) begin
        int p = j - int'(hstart);
        if (p < COLS * CW * n) begin
          e.v = 1; e.r = m_row; e.l = m_gl;
          e.c = p / (CW * n); e.d = (p % (CW * n)) / n;
        end
      end
      // R9 zero addresses outside the drawn area
      e.tag = (e.v != 0 || t == "R7" || t == "R8") ? t : "R9";
      q.push_back(e);
    end
    hsync_stb = 1'b1;
    @(negedge clk);
    hsync_stb = 1'b0;
    mon_on = 1'b1;
    wait (q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0;
  endtask

  // R8 frame strobe, optionally with a coincident line strobe
  task automatic frame_strobe(bit with_line);
    vsync_stb = 1'b1;
    hsync_stb = with_line;
    @(negedge clk);
    vsync_stb = 1'b0;
    hsync_stb = 1'b0;
    model_clear();
    @(posedge clk);
    #2;
    check(frame_win == 1'b0 && pix_valid == 1'b0, "R8",
          $sformatf("w%0d v%0d", frame_win, pix_valid), "w0 v0");
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (4) @(posedge clk);
    #2;
    // R1 reset state
    check(pix_valid == 0 && frame_win == 0 && mem_row == 0 && mem_col == 0 &&
          glyph_line == 0 && glyph_dot == 0, "R1",
          $sformatf("v%0d w%0d c%0d", pix_valid, frame_win, mem_col), "all zero");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Normal size frame, vstart 2, hstart 5: R2 start line, R4 sweep, R6 heights, R7 end
    vstart = 6'd2; hstart = 6'd5; row_size = '0;
    frame_strobe(1'b0);
    for (int ln = 0; ln < 222; ln++) begin
      if (ln == 2)       run_line(5 + 288 + 3, "R4");
      else if (ln < 3)   run_line(8, "R2");
      else               run_line(8, "R6");
    end

    // Mixed sizes: row0 3x, row1 2x, row2 code 11, rest 1x; hstart 0 (R5, R6)
    vstart = 6'd0; hstart = 6'd0;
    row_size = 24'b00_00_00_00_00_00_00_00_00_11_01_10;
    frame_strobe(1'b0);
    for (int ln = 0; ln < 274; ln++) begin
      if (ln == 0)        run_line(864 + 3, "R5");
      else if (ln == 54)  run_line(576 + 3, "R5");
      else if (ln == 90)  run_line(288 + 3, "R5");
      else                run_line(9, "R6");
    end

    // Far horizontal boundary, hstart 63 (R3)
    hstart = 6'd63; row_size = '0;
    frame_strobe(1'b0);
    run_line(63 + 288 + 3, "R3");
    run_line(70, "R3");

    // Frame strobe mid-page with coincident line strobe (R8)
    hstart = 6'd1;
    run_line(12, "R8");
    vstart = 6'd1;
    frame_strobe(1'b1);
    run_line(12, "R8");
    run_line(12, "R8");
    run_line(12, "R8");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule